// File: doc/BRIEF.md
# Load-Mode Entry Detector

This block watches a device's reset and program-store-enable levels after power-on and decides whether the device goes into its program-load session. Entry needs two conditions at once: the reset level must be high and the program-store-enable line must be held low. Once the session is armed, the block waits for whichever arrives first. One possibility is a falling edge on the parallel program strobe. The other is an asynchronous carriage-return character (0x0D) on the receive line. It then latches a serial or parallel selection. For serial loading it also reports which of four fixed host rates the carriage return was sent at.

The rate is found in two steps. The width of the start bit is measured, then matched against a tolerance window around each candidate bit period. The character is then sampled in mid-bit at the chosen rate and must decode as 0x0D with a high stop bit. Any other result throws the attempt away and hunting starts again. Two port-2 mode pins must both be high for a serial session; if either one is low, the session is parallel. The first parallel strobe after power-on also sets the initial memory partition: an 8 KB range whose lower 4 KB holds program code and whose upper 4 KB holds data.

States: `LM_POR_WAIT` (power-on delay running), `LM_IDLE` (normal operation), `LM_ARMED` (entry held, no choice made yet), `LM_SERIAL` and `LM_PARALLEL` (mode latched). Transitions: POR_WAIT to IDLE when the delay expires. IDLE to ARMED when entry is present. ARMED to PARALLEL on a strobe, or when either mode pin is low. ARMED to SERIAL when a carriage return is accepted. ARMED, SERIAL or PARALLEL go back to IDLE as soon as entry is lost. The rate finder inside has its own states: `RF_WAIT_IDLE`, `RF_WAIT_FALL`, `RF_MEASURE` and `RF_SAMPLE`.

Top module: `loadmode_entry`

## Requirements
- R1: `load_active` is high only while the synchronised reset level is high and the program-store-enable level is low. When either condition is lost, `load_active`, `serial_mode` and `parallel_mode` fall within 4 clocks.
- R2: Entry conditions are ignored until POR_CYCLES clocks (default 21504) have passed since `por_n` was released.
- R3: In the armed state, a falling edge on `prog_n` selects the parallel session (`parallel_mode`=1, `serial_mode`=0).
- R4: In the armed state, a low level on either `mode_pin_hi` or `mode_pin_lo` selects the parallel session without a strobe. A serial selection happens only while both pins are high.
- R5: A 0x0D character (8 data bits sent LSB first, one low start bit, one high stop bit) at 9600, 2400, 1200 or 300 bps selects the serial session. `baud_code` then reads 0, 1, 2 or 3 for those rates.
- R6: A character whose start bit has a valid width but whose data is not 0x0D, or whose stop bit is low, is rejected. The block stays armed, and a later 0x0D in the same session is still accepted.
- R7: A low pulse whose width lies outside every window of plus or minus a quarter of a candidate bit period is rejected. The block stays armed.
- R8: Once latched, a mode stays until the session ends. In serial mode, strobes have no effect, including no effect on the partition. In parallel mode, characters have no effect.
- R9: Before any strobe, `part_valid`=0, `range_code`=0 and `code_limit`=0. The first strobe accepted in the armed or parallel state sets `part_valid`=1, `range_code`=2'b01 (8 KB), and `code_limit`=0x1000: program code at 0x0000 to 0x0FFF, data from 0x1000.
- R10: The partition outputs survive the end of a session, and only `por_n` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_lvl | input | 1 | Device reset pin level (high = reset) |
| psen_n_lvl | input | 1 | Program-store-enable pin level (low = forced) |
| prog_n | input | 1 | Parallel program / security-set strobe, active low |
| mode_pin_hi | input | 1 | Upper port-2 mode pin level |
| mode_pin_lo | input | 1 | Lower port-2 mode pin level |
| rx_line | input | 1 | Serial receive line, idle high |
| load_active | output | 1 | Program-load session active |
| serial_mode | output | 1 | Serial loading latched |
| parallel_mode | output | 1 | Parallel loading latched |
| baud_code | output | 2 | Detected rate: 0=9600, 1=2400, 2=1200, 3=300 |
| part_valid | output | 1 | Initial partition has been applied |
| range_code | output | 2 | Memory range code, 2'b01 = 8 KB |
| code_limit | output | ADDR_W | First data address above program code |

## Verification
The assertions assume that every input pin reaches the logic only through the two-flop synchroniser. They also assume that `por_n` is the only way to clear state, so properties about the latched mode and the sticky partition hold only between power-on resets. The bench changes pins only on falling clock edges, and keeps the session pins stable for many clocks around each character. Characters are sent with exact whole-clock bit periods, so a decoded rate depends only on the measured start-bit width. Sessions are closed and reopened between table entries, so no attempt carries state into the next one.

// File: rtl/lme_pkg.sv
package lme_pkg;

    typedef enum logic [2:0] {
        LM_POR_WAIT,
        LM_IDLE,
        LM_ARMED,
        LM_SERIAL,
        LM_PARALLEL
    } lm_state_t;

    typedef enum logic [1:0] {
        RF_WAIT_IDLE,
        RF_WAIT_FALL,
        RF_MEASURE,
        RF_SAMPLE
    } rf_state_t;

    localparam int unsigned NUM_RATES = 4;
    localparam logic [7:0]  CR_CODE   = 8'h0D;
    localparam logic [1:0]  RANGE_8K  = 2'b01;

    // candidate host rates, fastest first; the index is the reported code
    function automatic int unsigned rate_bps(input int unsigned idx);
        case (idx)
            0:       return 9600;
            1:       return 2400;
            2:       return 1200;
            default: return 300;
        endcase
    endfunction

    function automatic int unsigned bit_clocks(input int unsigned clk_hz,
                                               input int unsigned idx);
        return clk_hz / rate_bps(idx);
    endfunction

endpackage

// File: rtl/lme_sync.sv
module lme_sync #(
    parameter int unsigned      W    = 1,
    parameter logic [W-1:0]     INIT = '0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_r, stab_r;
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                meta_r <= INIT[g];
                stab_r <= INIT[g];
            end else begin
                meta_r <= d[g];
                stab_r <= meta_r;
            end
        end
        assign q[g] = stab_r;
    end
endmodule

// File: rtl/lme_por_delay.sv
module lme_por_delay #(
    parameter int unsigned POR_CYCLES = 21504
) (
    input  logic clk,
    input  logic por_n,
    output logic done
);
    localparam int unsigned CW = $clog2(POR_CYCLES + 1);

    logic [CW-1:0] cnt_r;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_r <= '0;
            done  <= 1'b0;
        end else if (!done) begin
            if (cnt_r == CW'(POR_CYCLES - 1)) begin
                done <= 1'b1;
            end else begin
                cnt_r <= cnt_r + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lme_rate_finder.sv
module lme_rate_finder
    import lme_pkg::*;
#(
    parameter int unsigned CLK_HZ = 16_000_000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       enable,
    input  logic       rx,
    output logic       found,
    output logic [1:0] rate,
    output logic       reject
);
    localparam int unsigned P_MAX  = bit_clocks(CLK_HZ, NUM_RATES - 1);
    localparam int unsigned HI_MAX = P_MAX + P_MAX / 4;
    localparam int unsigned CW     = $clog2(HI_MAX + 2);

    rf_state_t            st_r;
    logic [CW-1:0]        cnt_r;
    logic [CW-1:0]        tmr_r;
    logic [1:0]           rate_q;
    logic [7:0]           shreg_r;
    logic [3:0]           bit_n;
    logic [NUM_RATES-1:0] win_hit;
    logic [CW-1:0]        per_tab [NUM_RATES];
    logic [1:0]           pick;

    // one acceptance window per candidate bit period
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_win
        localparam int unsigned PER = bit_clocks(CLK_HZ, g);
        localparam logic [CW-1:0] LO = CW'(PER - PER / 4);
        localparam logic [CW-1:0] HI = CW'(PER + PER / 4);
        assign per_tab[g] = CW'(PER);
        assign win_hit[g] = (cnt_r >= LO) && (cnt_r <= HI);
    end

    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (win_hit[i]) pick = 2'(i);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_r    <= RF_WAIT_IDLE;
            cnt_r   <= '0;
            tmr_r   <= '0;
            rate_q  <= '0;
            shreg_r <= '0;
            bit_n   <= '0;
            found   <= 1'b0;
            reject  <= 1'b0;
            rate    <= '0;
        end else if (!enable) begin
            st_r   <= RF_WAIT_IDLE;
            found  <= 1'b0;
            reject <= 1'b0;
        end else begin
            found  <= 1'b0;
            reject <= 1'b0;
            unique case (st_r)
                RF_WAIT_IDLE: begin
                    if (rx) st_r <= RF_WAIT_FALL;
                end
                RF_WAIT_FALL: begin
                    if (!rx) begin
                        cnt_r <= CW'(1);
                        st_r  <= RF_MEASURE;
                    end
                end
                RF_MEASURE: begin
                    if (!rx) begin
                        if (cnt_r > CW'(HI_MAX)) begin
                            reject <= 1'b1;
                            st_r   <= RF_WAIT_IDLE;
                        end else begin
                            cnt_r <= cnt_r + 1'b1;
                        end
                    end else if (|win_hit) begin
                        rate_q <= pick;
                        tmr_r  <= (per_tab[pick] >> 1) - 1'b1;
                        bit_n  <= '0;
                        st_r   <= RF_SAMPLE;
                    end else begin
                        reject <= 1'b1;
                        st_r   <= RF_WAIT_FALL;
                    end
                end
                RF_SAMPLE: begin
                    if (tmr_r != '0) begin
                        tmr_r <= tmr_r - 1'b1;
                    end else begin
                        tmr_r <= per_tab[rate_q] - 1'b1;
                        if (bit_n == 4'd8) begin
                            st_r <= RF_WAIT_IDLE;
                            if (rx && (shreg_r == CR_CODE)) begin
                                found <= 1'b1;
                                rate  <= rate_q;
                            end else begin
                                reject <= 1'b1;
                            end
                        end else begin
                            shreg_r <= {rx, shreg_r[7:1]};
                            bit_n   <= bit_n + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/loadmode_entry.sv
module loadmode_entry
    import lme_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 16_000_000,
    parameter int unsigned POR_CYCLES = 21504,
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned CODE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_lvl,
    input  logic              psen_n_lvl,
    input  logic              prog_n,
    input  logic              mode_pin_hi,
    input  logic              mode_pin_lo,
    input  logic              rx_line,
    output logic              load_active,
    output logic              serial_mode,
    output logic              parallel_mode,
    output logic [1:0]        baud_code,
    output logic              part_valid,
    output logic [1:0]        range_code,
    output logic [ADDR_W-1:0] code_limit
);
    localparam int unsigned NSYNC = 6;

    logic [NSYNC-1:0] pins_s;
    logic rst_s, psen_s, prog_s, hi_s, lo_s, rx_s;
    logic prog_q, prog_fall, entry_s, pins_serial;
    logic por_done;
    logic cr_found, cr_reject;
    logic [1:0] cr_rate;
    logic [1:0] baud_q;
    logic part_q;
    lm_state_t state_r, state_nx;

    lme_sync #(
        .W    (NSYNC),
        .INIT (6'b011111)
    ) sync_i (
        .clk   (clk),
        .por_n (por_n),
        .d     ({rst_lvl, psen_n_lvl, prog_n, mode_pin_hi, mode_pin_lo, rx_line}),
        .q     (pins_s)
    );

    assign {rst_s, psen_s, prog_s, hi_s, lo_s, rx_s} = pins_s;
    assign entry_s     = rst_s && !psen_s;
    assign pins_serial = hi_s && lo_s;
    assign prog_fall   = prog_q && !prog_s;

    lme_por_delay #(
        .POR_CYCLES (POR_CYCLES)
    ) por_i (
        .clk   (clk),
        .por_n (por_n),
        .done  (por_done)
    );

    lme_rate_finder #(
        .CLK_HZ (CLK_HZ)
    ) finder_i (
        .clk    (clk),
        .por_n  (por_n),
        .enable (state_r == LM_ARMED),
        .rx     (rx_s),
        .found  (cr_found),
        .rate   (cr_rate),
        .reject (cr_reject)
    );

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_r <= LM_POR_WAIT;
        else        state_r <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_r;
        unique case (state_r)
            LM_POR_WAIT: if (por_done) state_nx = LM_IDLE;
            LM_IDLE:     if (entry_s)  state_nx = LM_ARMED;
            LM_ARMED: begin
                if (!entry_s)         state_nx = LM_IDLE;
                else if (prog_fall)   state_nx = LM_PARALLEL;
                else if (!pins_serial) state_nx = LM_PARALLEL;
                else if (cr_found)    state_nx = LM_SERIAL;
            end
            LM_SERIAL:   if (!entry_s) state_nx = LM_IDLE;
            LM_PARALLEL: if (!entry_s) state_nx = LM_IDLE;
            default:     state_nx = LM_POR_WAIT;
        endcase
    end

    // captured data: strobe edge, rate, sticky partition
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            prog_q <= 1'b1;
            baud_q <= '0;
            part_q <= 1'b0;
        end else begin
            prog_q <= prog_s;
            if (state_r == LM_ARMED && state_nx == LM_SERIAL) baud_q <= cr_rate;
            if (prog_fall && entry_s &&
                (state_r == LM_ARMED || state_r == LM_PARALLEL)) part_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        load_active   = (state_r == LM_ARMED) || (state_r == LM_SERIAL) ||
                        (state_r == LM_PARALLEL);
        serial_mode   = (state_r == LM_SERIAL);
        parallel_mode = (state_r == LM_PARALLEL);
        baud_code     = serial_mode ? baud_q : 2'b00;
        part_valid    = part_q;
        range_code    = part_q ? RANGE_8K : 2'b00;
        code_limit    = part_q ? ADDR_W'(CODE_BYTES) : '0;
    end

endmodule

// File: rtl/lme_checker.sv
module lme_checker (
    input logic       clk,
    input logic       por_n,
    input logic       entry_s,
    input logic       hi_s,
    input logic       lo_s,
    input logic       prog_fall,
    input logic       por_done,
    input logic       load_active,
    input logic       serial_mode,
    input logic       parallel_mode,
    input logic [1:0] baud_code,
    input logic       part_valid
);
    assert_exit_R1: assert property (@(posedge clk) disable iff (!por_n)
        !entry_s |=> !load_active);

    assert_por_R2: assert property (@(posedge clk) disable iff (!por_n)
        !por_done |-> !load_active);

    assert_par_cause_R3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(parallel_mode) |-> $past(prog_fall || !(hi_s && lo_s)));

    assert_ser_pins_R4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(serial_mode) |-> $past(hi_s && lo_s));

    assert_rate_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
        (serial_mode && $past(serial_mode)) |-> $stable(baud_code));

    assert_par_latch_R8: assert property (@(posedge clk) disable iff (!por_n)
        parallel_mode |=> (parallel_mode || !load_active));

    assert_ser_latch_R8: assert property (@(posedge clk) disable iff (!por_n)
        serial_mode |=> (serial_mode || !load_active));

    assert_part_cause_R9: assert property (@(posedge clk) disable iff (!por_n)
        $rose(part_valid) |-> $past(prog_fall));

    assert_part_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
        part_valid |=> part_valid);
endmodule

bind loadmode_entry lme_checker chk_i (
    .clk           (clk),
    .por_n         (por_n),
    .entry_s       (entry_s),
    .hi_s          (hi_s),
    .lo_s          (lo_s),
    .prog_fall     (prog_fall),
    .por_done      (por_done),
    .load_active   (load_active),
    .serial_mode   (serial_mode),
    .parallel_mode (parallel_mode),
    .baud_code     (baud_code),
    .part_valid    (part_valid)
);

// File: tb/loadmode_entry_tb_top.sv
`timescale 1ns/1ps
module loadmode_entry_tb_top;
    localparam int unsigned CLK_HZ = 96000;   // bit periods 10/40/80/320 clocks
    localparam int unsigned PORC   = 200;
    localparam int unsigned AW     = 16;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_lvl = 1'b0, psen_n_lvl = 1'b1, prog_n = 1'b1;
    logic mode_pin_hi = 1'b1, mode_pin_lo = 1'b1, rx_line = 1'b1;
    logic load_active, serial_mode, parallel_mode, part_valid;
    logic [1:0] baud_code, range_code;
    logic [AW-1:0] code_limit;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    loadmode_entry #(
        .CLK_HZ (CLK_HZ), .POR_CYCLES (PORC), .ADDR_W (AW), .CODE_BYTES (4096)
    ) dut_i (
        .clk (clk), .por_n (por_n), .rst_lvl (rst_lvl), .psen_n_lvl (psen_n_lvl),
        .prog_n (prog_n), .mode_pin_hi (mode_pin_hi), .mode_pin_lo (mode_pin_lo),
        .rx_line (rx_line), .load_active (load_active), .serial_mode (serial_mode),
        .parallel_mode (parallel_mode), .baud_code (baud_code), .part_valid (part_valid),
        .range_code (range_code), .code_limit (code_limit)
    );

    typedef struct packed {
        logic [15:0] per;
        logic [7:0]  ch;
        logic        stop;
        logic        ser;
        logic [1:0]  baud;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'd10,  8'h0D, 1'b1, 1'b1, 2'd0},   // R5 9600
        '{16'd40,  8'h0D, 1'b1, 1'b1, 2'd1},   // R5 2400
        '{16'd80,  8'h0D, 1'b1, 1'b1, 2'd2},   // R5 1200
        '{16'd320, 8'h0D, 1'b1, 1'b1, 2'd3},   // R5 300
        '{16'd10,  8'h41, 1'b1, 1'b0, 2'd0},   // R6 wrong data
        '{16'd40,  8'h0D, 1'b0, 1'b0, 2'd0},   // R6 low stop bit
        '{16'd10,  8'h0E, 1'b1, 1'b0, 2'd0},   // R7 start too wide
        '{16'd20,  8'h0D, 1'b1, 1'b0, 2'd0}    // R7 period between rates
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_char(input int per, input logic [7:0] ch, input logic stop);
        rx_line = 1'b0;
        ticks(per);
        for (int b = 0; b < 8; b++) begin
            rx_line = ch[b];
            ticks(per);
        end
        rx_line = stop;
        ticks(per);
        rx_line = 1'b1;
        ticks(per);
    endtask

    task automatic open_session;
        rst_lvl = 1'b1; psen_n_lvl = 1'b0;
        ticks(10);
    endtask

    task automatic close_session;
        rst_lvl = 1'b0; psen_n_lvl = 1'b1;
        ticks(10);
    endtask

    task automatic strobe;
        prog_n = 1'b0; ticks(5);
        prog_n = 1'b1; ticks(10);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // reset state and R2: entry held from time zero
        rst_lvl = 1'b1; psen_n_lvl = 1'b0;
        ticks(5);
        chk("reset load_active", load_active, 0);
        chk("reset serial_mode", serial_mode, 0);
        chk("reset parallel_mode", parallel_mode, 0);
        chk("R9 reset part_valid", part_valid, 0);
        chk("R9 reset range_code", range_code, 0);
        chk("R9 reset code_limit", code_limit, 0);
        por_n = 1'b1;
        ticks(PORC - 10);
        chk("R2 before delay", load_active, 0);
        ticks(20);
        chk("R2 after delay", load_active, 1);

        // table walk: R5, R6, R7, R1
        for (int v = 0; v < 8; v++) begin
            open_session();
            send_char(int'(VECS[v].per), VECS[v].ch, VECS[v].stop);
            ticks(20);
            chk($sformatf("R5/R6/R7 vec%0d serial", v), serial_mode, VECS[v].ser);
            chk($sformatf("R5 vec%0d baud", v), baud_code, VECS[v].ser ? VECS[v].baud : 2'd0);
            chk($sformatf("R6/R7 vec%0d still armed", v), load_active, 1);
            chk($sformatf("R6/R7 vec%0d parallel", v), parallel_mode, 0);
            close_session();
            chk($sformatf("R1 vec%0d exit", v), load_active, 0);
        end

        // R6: rejected character then carriage return in the same session
        open_session();
        send_char(10, 8'h41, 1'b1);
        ticks(20);
        send_char(80, 8'h0D, 1'b1);
        ticks(20);
        chk("R6 retry serial", serial_mode, 1);
        chk("R6 retry baud", baud_code, 2);
        // R8: strobe ignored in serial mode
        strobe();
        chk("R8 serial kept", serial_mode, 1);
        chk("R8 no parallel", parallel_mode, 0);
        chk("R8 no partition", part_valid, 0);
        close_session();

        // R3, R9: strobe selects parallel and sets partition
        open_session();
        strobe();
        chk("R3 parallel", parallel_mode, 1);
        chk("R3 serial off", serial_mode, 0);
        chk("R9 part_valid", part_valid, 1);
        chk("R9 range_code", range_code, 2'b01);
        chk("R9 code_limit", code_limit, 16'h1000);
        // R8: character ignored in parallel mode
        send_char(10, 8'h0D, 1'b1);
        ticks(20);
        chk("R8 parallel kept", parallel_mode, 1);
        chk("R8 serial off", serial_mode, 0);
        // R1 exit via program-store-enable release, R10 persistence
        psen_n_lvl = 1'b1;
        ticks(4);
        chk("R1 psen exit", load_active, 0);
        chk("R1 psen exit parallel", parallel_mode, 0);
        chk("R10 part kept", part_valid, 1);
        chk("R10 limit kept", code_limit, 16'h1000);
        rst_lvl = 1'b0;
        ticks(10);

        // R4: mode pin low forces parallel
        mode_pin_lo = 1'b0;
        open_session();
        chk("R4 parallel by pin", parallel_mode, 1);
        send_char(10, 8'h0D, 1'b1);
        ticks(20);
        chk("R4 no serial", serial_mode, 0);
        close_session();
        mode_pin_lo = 1'b1;
        mode_pin_hi = 1'b0;
        open_session();
        chk("R4 parallel by upper pin", parallel_mode, 1);
        close_session();
        mode_pin_hi = 1'b1;

        // R1: reset high but program-store-enable not forced
        rst_lvl = 1'b1; psen_n_lvl = 1'b1;
        ticks(10);
        chk("R1 no entry", load_active, 0);
        send_char(10, 8'h0D, 1'b1);
        ticks(20);
        chk("R1 no serial", serial_mode, 0);
        rst_lvl = 1'b0;
        ticks(5);

        // R10: only power-on reset clears partition
        por_n = 1'b0;
        ticks(3);
        chk("R10 cleared by por", part_valid, 0);
        chk("R10 range cleared", range_code, 0);
        por_n = 1'b1;
        ticks(5);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule